// File: doc/BRIEF.md
# TDM Serial Audio Input Formatter

This block receives time-division-multiplexed serial audio on up to four data lanes and turns it into a stream of tagged samples. The bit clock and the frame sync come from one of sixteen source interfaces, selected by software. The block runs in the system clock domain and oversamples the chosen bit clock. It synchronizes the bit clock, the frame sync and the data lanes together, and captures data on each rising bit-clock edge.

A frame starts at a frame-sync edge. The first data bit is captured a programmed number of bit clocks after that edge. Each slot is then packed into a 32-bit sample that is left-aligned, with unused low bits cleared. Each logical lane can be fed from any physical lane. Each slot of each lane can be enabled or muted separately. Enabled samples leave on a valid/ready stream tagged with lane and slot. They come out in slot order, and within a slot in lane order. Samples that are still waiting when a newer slot completes are dropped, and this is recorded in a sticky flag.

Software brings the block up in a fixed order. It clears both side resets, releases the output side, then releases the input side, and finally sets enable.

Top module: `tdm_rx_formatter`

## Requirements
- R1: After reset, the control word reads 0 with both side resets asserted. The swap word reads 0x76543210, every slot-enable and slot-mute word reads 0, and `smp_valid` is low.
- R2: Registers sit at word-aligned byte offsets: control 0x00, swap 0x04, slot-enable lanes 0..3 at 0x08..0x14, status 0x18, mute value 0x1C, slot-mute lanes 0..3 at 0x20..0x2C. The control fields are: enable bit 31, word-select mode bit 30, output-side run bit 29 (0 = held in reset), input-side run bit 28 (0 = held in reset), frame-sync invert bit 25, source select bits 23:20, skew bits 18:16, LSB-first bit 5, and slot bit count (width minus one) bits 4:0. Undefined control bits read 0.
- R3: With LSB-first clear, the first bit of a slot lands at bit 31 and later bits fill downward. A slot holds the bit count plus one bits, and the remaining low bits read 0.
- R4: With LSB-first set, the first bit of a W-bit slot lands at bit 32-W and later bits fill upward. The sample stays left-aligned with its low bits at 0.
- R5: If the frame-sync edge is seen on bit-clock rising edge n, the first data bit of slot 0 is captured on rising edge n+skew.
- R6: In pulse mode, a frame starts at a rising edge of the frame sync. In word-select mode, it starts at a falling edge, and a rising edge mid-frame does not restart slot counting. When the invert bit is set, the frame sync is inverted before either decode.
- R7: Only the bit clock and frame sync of the selected source affect capture.
- R8: A slot s of lane L is emitted only if bit s of that lane's slot-enable word is set. Samples come out in slot order, lanes 0 to 3 within a slot, with `smp_lane` = L and `smp_slot` = s.
- R9: An enabled slot whose bit is set in its lane's slot-mute word outputs the full 32-bit mute value in place of the received data.
- R10: Logical lane L takes its data from the physical lane numbered in bits 4L+3:4L of the swap word.
- R11: Status bit 0 is set when a slot with enabled samples completes while samples of the previous slot are still pending after this cycle's transfer. The newer slot's samples then replace the pending ones. The flag stays set until a write of 1 to status bit 0 clears it, and a new overflow in the same cycle wins over the clear.
- R12: While enable or the input-side run bit is 0, nothing is captured. While the output-side run bit is 0, pending samples are dropped and `smp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| src_bclk | input | 16 | Bit clock of each source interface |
| src_fsync | input | 16 | Frame sync of each source interface |
| lane_in | input | 4 | Physical serial data lanes |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Consumer accepts the sample |
| smp_data | output | 32 | Left-aligned sample |
| smp_lane | output | 2 | Logical lane of the sample |
| smp_slot | output | 5 | Slot index of the sample |

## Verification
Two events can fall in the same cycle: a slot completing and the output stream still holding samples from the previous slot. The bench provokes this by holding `smp_ready` low across a frame with two enabled slots on lane 0. It then checks that the overflow flag is set, that the presented sample is the second slot's data tagged slot 1, and that the flag clears on a write of 1. Every other pattern runs with the consumer always ready, and the scoreboard requires that no sample is lost or reordered.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    localparam int SAMPLE_W  = 32;
    localparam int BITNUM_W  = 5;
    localparam int SKEW_W    = 3;
    localparam int SRC_W     = 4;
    localparam int NUM_SRC   = 1 << SRC_W;
    localparam int NUM_LANES = 4;
    localparam int MASK_W    = 32;
    localparam int ADDR_W    = 6;

    localparam logic [3:0] W_CTRL    = 4'd0;
    localparam logic [3:0] W_SWAP    = 4'd1;
    localparam logic [3:0] W_EN0     = 4'd2;
    localparam logic [3:0] W_STAT    = 4'd6;
    localparam logic [3:0] W_MUTEVAL = 4'd7;
    localparam logic [3:0] W_MUTE0   = 4'd8;

    localparam logic [31:0] SWAP_IDENT = 32'h7654_3210;

    typedef struct packed {
        logic                enable;
        logic                ws_mode;
        logic                out_run;
        logic                in_run;
        logic                fs_inv;
        logic [SRC_W-1:0]    src_sel;
        logic [SKEW_W-1:0]   skew;
        logic                lsb_first;
        logic [BITNUM_W-1:0] bitnum;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c.enable    = w[31];
        c.ws_mode   = w[30];
        c.out_run   = w[29];
        c.in_run    = w[28];
        c.fs_inv    = w[25];
        c.src_sel   = w[23:20];
        c.skew      = w[18:16];
        c.lsb_first = w[5];
        c.bitnum    = w[4:0];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        return {c.enable, c.ws_mode, c.out_run, c.in_run, 2'b00, c.fs_inv, 1'b0,
                c.src_sel, 1'b0, c.skew, 10'd0, c.lsb_first, c.bitnum};
    endfunction

endpackage

// File: rtl/tdm_rx_regs.sv
module tdm_rx_regs
    import tdm_rx_pkg::*;
#(
    parameter int LANES = NUM_LANES,
    parameter int MW    = MASK_W,
    parameter int AW    = ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [AW-1:0]            addr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    input  logic                     ovf_set,
    output ctrl_t                    cfg,
    output logic [4*LANES-1:0]       swap_map,
    output logic [LANES-1:0][MW-1:0] slot_en,
    output logic [LANES-1:0][MW-1:0] slot_mute,
    output logic [31:0]              mute_val
);

    logic [31:0] swap_q;
    logic        ovf_q;
    logic [3:0]  wsel;
    logic        stat_clr;

    assign wsel     = (addr[1:0] == 2'b00) ? addr[5:2] : 4'hF;
    assign swap_map = swap_q[4*LANES-1:0];
    assign stat_clr = wr && (wsel == W_STAT) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            swap_q    <= SWAP_IDENT;
            slot_en   <= '0;
            slot_mute <= '0;
            mute_val  <= '0;
        end else if (wr) begin
            if (wsel == W_CTRL)    cfg      <= ctrl_from_word(wdata);
            if (wsel == W_SWAP)    swap_q   <= wdata;
            if (wsel == W_MUTEVAL) mute_val <= wdata;
            for (int l = 0; l < LANES; l++) begin
                if (wsel == W_EN0 + 4'(l))   slot_en[l]   <= wdata[MW-1:0];
                if (wsel == W_MUTE0 + 4'(l)) slot_mute[l] <= wdata[MW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= 1'b0;
        else     ovf_q <= (ovf_q && !stat_clr) || ovf_set;
    end

    always_comb begin
        rdata = '0;
        case (wsel)
            W_CTRL:    rdata = ctrl_to_word(cfg);
            W_SWAP:    rdata = swap_q;
            W_STAT:    rdata = {31'd0, ovf_q};
            W_MUTEVAL: rdata = mute_val;
            default: begin
                for (int l = 0; l < LANES; l++) begin
                    if (wsel == W_EN0 + 4'(l))   rdata = 32'(slot_en[l]);
                    if (wsel == W_MUTE0 + 4'(l)) rdata = 32'(slot_mute[l]);
                end
            end
        endcase
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !stat_clr) |=> ovf_q);                       // R11
    AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> ovf_q);                                    // R11

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
    import tdm_rx_pkg::*;
#(
    parameter int LANES = NUM_LANES,
    parameter int SRCS  = NUM_SRC,
    parameter int SW    = SAMPLE_W,
    parameter int SKW   = SKEW_W,
    parameter int MW    = MASK_W,
    localparam int BW   = $clog2(SW),
    localparam int SELW = $clog2(SRCS),
    localparam int SLW  = $clog2(MW),
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int HIST = (1 << SKW) - 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     srst,
    input  logic                     ws_mode,
    input  logic                     fs_inv,
    input  logic [SELW-1:0]          src_sel,
    input  logic [SKW-1:0]           skew,
    input  logic                     lsb_first,
    input  logic [BW-1:0]            bitnum,
    input  logic [4*LANES-1:0]       swap_map,
    input  logic [SRCS-1:0]          src_bclk,
    input  logic [SRCS-1:0]          src_fsync,
    input  logic [LANES-1:0]         din,
    output logic                     slot_done,
    output logic [SLW-1:0]           slot_idx,
    output logic [LANES-1:0][SW-1:0] words
);

    localparam logic [BW-1:0] TOPBIT = BW'(SW - 1);

    logic             bclk_s1, bclk_s2, bclk_s3, fs_s1, fs_s2;
    logic [LANES-1:0] din_s1, din_s2, lane_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_s1 <= 1'b0; bclk_s2 <= 1'b0; bclk_s3 <= 1'b0;
            fs_s1   <= 1'b0; fs_s2   <= 1'b0;
            din_s1  <= '0;   din_s2  <= '0;
        end else begin
            bclk_s1 <= src_bclk[src_sel];
            bclk_s2 <= bclk_s1;
            bclk_s3 <= bclk_s2;
            fs_s1   <= src_fsync[src_sel];
            fs_s2   <= fs_s1;
            din_s1  <= din;
            din_s2  <= din_s1;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_remap
        logic [3:0] phys;
        assign phys        = swap_map[4*l +: 4];
        assign lane_bit[l] = (int'(phys) < LANES) ? din_s2[phys[LW-1:0]] : 1'b0;
    end

    logic                     rise, fsi, fs_prev, fs_edge, start, running, active, last;
    logic [HIST-1:0]          hist_q;
    logic [HIST:0]            hist_full;
    logic [BW-1:0]            bit_cnt, cur_bit, pos;
    logic [SLW-1:0]           slot_cnt, cur_slot;
    logic [LANES-1:0][SW-1:0] acc_q, acc_next;

    assign rise      = bclk_s2 && !bclk_s3;
    assign fsi       = fs_s2 ^ fs_inv;
    assign fs_edge   = ws_mode ? (fs_prev && !fsi) : (fsi && !fs_prev);
    assign hist_full = {hist_q, fs_edge};
    assign start     = hist_full[skew];
    assign active    = rise && (start || running);
    assign cur_bit   = start ? '0 : bit_cnt;
    assign cur_slot  = start ? '0 : slot_cnt;
    assign pos       = lsb_first ? (TOPBIT - bitnum + cur_bit) : (TOPBIT - cur_bit);
    assign last      = (cur_bit >= bitnum);

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            acc_next[l]      = (cur_bit == '0) ? '0 : acc_q[l];
            acc_next[l][pos] = lane_bit[l];
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            fs_prev  <= 1'b0;
            hist_q   <= '0;
            running  <= 1'b0;
            bit_cnt  <= '0;
            slot_cnt <= '0;
            acc_q    <= '0;
        end else if (rise) begin
            fs_prev <= fsi;
            hist_q  <= {hist_q[HIST-2:0], fs_edge};
            if (active) begin
                running <= 1'b1;
                acc_q   <= acc_next;
                if (last) begin
                    bit_cnt  <= '0;
                    slot_cnt <= cur_slot + 1'b1;
                end else begin
                    bit_cnt  <= cur_bit + 1'b1;
                    slot_cnt <= cur_slot;
                end
            end
        end
    end

    assign slot_done = active && last;
    assign slot_idx  = cur_slot;
    assign words     = acc_next;

    AST_BIT_WITHIN_SLOT: assert property (@(posedge clk) disable iff (srst)
        (rise && running && !start) |-> (bit_cnt <= bitnum));  // R3

endmodule

// File: rtl/tdm_rx_outq.sv
module tdm_rx_outq
    import tdm_rx_pkg::*;
#(
    parameter int LANES = NUM_LANES,
    parameter int SW    = SAMPLE_W,
    parameter int MW    = MASK_W,
    localparam int SLW  = $clog2(MW),
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                     clk,
    input  logic                     srst,
    input  logic                     load,
    input  logic [LANES-1:0]         load_mask,
    input  logic [SLW-1:0]           load_slot,
    input  logic [LANES-1:0][SW-1:0] load_data,
    input  logic                     ready,
    output logic                     valid,
    output logic [SW-1:0]            data,
    output logic [LW-1:0]            lane,
    output logic [SLW-1:0]           slot,
    output logic                     ovf_set
);

    logic [LANES-1:0]         pend_q, pop_mask, pend_after;
    logic [LANES-1:0][SW-1:0] hold_q;
    logic [SLW-1:0]           slot_q;
    logic                     take;

    always_comb begin
        lane = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend_q[i]) lane = LW'(i);
        end
    end

    assign valid      = |pend_q;
    assign data       = hold_q[lane];
    assign slot       = slot_q;
    assign pop_mask   = (valid && ready) ? (LANES'(1) << lane) : '0;
    assign pend_after = pend_q & ~pop_mask;
    assign take       = load && (|load_mask);
    assign ovf_set    = take && (|pend_after);

    always_ff @(posedge clk) begin
        if (srst) begin
            pend_q <= '0;
            hold_q <= '0;
            slot_q <= '0;
        end else if (take) begin
            pend_q <= load_mask;
            hold_q <= load_data;
            slot_q <= load_slot;
        end else begin
            pend_q <= pend_after;
        end
    end

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (srst)
        (valid && !ready && !take) |=> (valid && $stable(data) && $stable(lane))); // R8
    AST_LANE_ASCENDING: assert property (@(posedge clk) disable iff (srst)
        (valid && ready && !take) |=> (!valid || (lane > $past(lane))));           // R8

endmodule

// File: rtl/tdm_rx_formatter.sv
module tdm_rx_formatter
    import tdm_rx_pkg::*;
#(
    parameter int LANES = NUM_LANES,
    parameter int SRCS  = NUM_SRC,
    parameter int AW    = ADDR_W,
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int SLW  = $clog2(MASK_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [SRCS-1:0]   src_bclk,
    input  logic [SRCS-1:0]   src_fsync,
    input  logic [LANES-1:0]  lane_in,
    output logic              smp_valid,
    input  logic              smp_ready,
    output logic [31:0]       smp_data,
    output logic [LW-1:0]     smp_lane,
    output logic [SLW-1:0]    smp_slot
);

    ctrl_t                          cfg;
    logic [4*LANES-1:0]             swap_map;
    logic [LANES-1:0][MASK_W-1:0]   slot_en, slot_mute;
    logic [31:0]                    mute_val;
    logic                           ovf_set, fe_srst, oq_srst, slot_done;
    logic [SLW-1:0]                 slot_idx;
    logic [LANES-1:0][SAMPLE_W-1:0] words, ld_data;
    logic [LANES-1:0]               ld_mask;

    assign fe_srst = rst || !(cfg.enable && cfg.in_run);
    assign oq_srst = rst || !cfg.out_run;

    tdm_rx_regs #(.LANES(LANES), .MW(MASK_W), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ovf_set  (ovf_set),
        .cfg      (cfg),
        .swap_map (swap_map),
        .slot_en  (slot_en),
        .slot_mute(slot_mute),
        .mute_val (mute_val)
    );

    tdm_rx_deser #(.LANES(LANES), .SRCS(SRCS), .SW(SAMPLE_W), .SKW(SKEW_W), .MW(MASK_W)) u_deser (
        .clk      (clk),
        .rst      (rst),
        .srst     (fe_srst),
        .ws_mode  (cfg.ws_mode),
        .fs_inv   (cfg.fs_inv),
        .src_sel  (cfg.src_sel),
        .skew     (cfg.skew),
        .lsb_first(cfg.lsb_first),
        .bitnum   (cfg.bitnum),
        .swap_map (swap_map),
        .src_bclk (src_bclk),
        .src_fsync(src_fsync),
        .din      (lane_in),
        .slot_done(slot_done),
        .slot_idx (slot_idx),
        .words    (words)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_select
        assign ld_mask[l] = slot_en[l][slot_idx];
        assign ld_data[l] = slot_mute[l][slot_idx] ? mute_val : words[l];
    end

    tdm_rx_outq #(.LANES(LANES), .SW(SAMPLE_W), .MW(MASK_W)) u_outq (
        .clk      (clk),
        .srst     (oq_srst),
        .load     (slot_done),
        .load_mask(ld_mask),
        .load_slot(slot_idx),
        .load_data(ld_data),
        .ready    (smp_ready),
        .valid    (smp_valid),
        .data     (smp_data),
        .lane     (smp_lane),
        .slot     (smp_slot),
        .ovf_set  (ovf_set)
    );

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !(cfg.enable && cfg.in_run) |-> !slot_done);           // R12
    AST_NO_VALID_IN_OUT_RESET: assert property (@(posedge clk) disable iff (rst)
        !cfg.out_run |=> !smp_valid);                          // R12

endmodule

// File: tb/tdm_rx_formatter_test.sv
module tdm_rx_formatter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] src_bclk = '0;
    logic [15:0] src_fsync = '1;
    logic [3:0]  lane_in = '0;
    logic        smp_valid;
    logic        smp_ready = 1'b1;
    logic [31:0] smp_data;
    logic [1:0]  smp_lane;
    logic [4:0]  smp_slot;

    always #10 clk = ~clk;

    tdm_rx_formatter uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_bclk(src_bclk),
        .src_fsync(src_fsync), .lane_in(lane_in), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .smp_data(smp_data), .smp_lane(smp_lane),
        .smp_slot(smp_slot)
    );

    int checks = 0;
    int errors = 0;
    int seen   = 0;
    int src    = 0;
    int fr     = 0;

    logic [31:0] b_en   [4];
    logic [31:0] b_mute [4];
    logic [31:0] b_swap;
    logic [31:0] b_mval;

    logic [31:0] q_data [$];
    int          q_lane [$];
    int          q_slot [$];
    string       q_tag  [$];

    localparam logic [31:0] EN  = 32'h8000_0000;
    localparam logic [31:0] WSM = 32'h4000_0000;
    localparam logic [31:0] ORN = 32'h2000_0000;
    localparam logic [31:0] IRN = 32'h1000_0000;
    localparam logic [31:0] INV = 32'h0200_0000;
    localparam logic [31:0] LSB = 32'h0000_0020;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pv(input int f, input int p, input int s);
        logic [31:0] a;
        a = 32'(f + 1) * 32'h0100_0193;
        a = a ^ (32'(p + 3) * 32'h9E37_79B9) ^ (32'(s + 7) * 32'h7F4A_7C15);
        return a ^ 32'hA5C3_0F1E;
    endfunction

    function automatic logic [31:0] topmask(input int w);
        return (w >= 32) ? 32'hFFFF_FFFF : ~((32'd1 << (32 - w)) - 32'd1);
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick(input logic fsraw, input logic [3:0] d);
        @(negedge clk);
        src_fsync[src] = fsraw;
        lane_in = d;
        repeat (2) @(negedge clk);
        src_bclk[src] = 1'b1;
        @(negedge clk);
        src_bclk[src] = 1'b0;
    endtask

    task automatic bring_up(input logic [31:0] fields);
        wr(6'h00, fields);
        wr(6'h00, fields | ORN);
        wr(6'h00, fields | ORN | IRN);
        wr(6'h00, fields | ORN | IRN | EN);
    endtask

    task automatic send_frame(input int skew, input int w, input int nslots, input int pad,
                              input bit ws, input bit inv, input bit lsb,
                              input bit push, input string tag);
        int f;
        f = skew + nslots * w + pad;
        if (push) begin
            for (int s = 0; s < nslots; s++) begin
                for (int l = 0; l < 4; l++) begin
                    if (b_en[l][s]) begin
                        if (b_mute[l][s]) q_data.push_back(b_mval);
                        else q_data.push_back(pv(fr, int'(b_swap[4*l +: 4]), s) & topmask(w));
                        q_lane.push_back(l);
                        q_slot.push_back(s);
                        q_tag.push_back(tag);
                    end
                end
            end
        end
        for (int t = 0; t < f; t++) begin
            logic       fsl;
            logic [3:0] d;
            int         k;
            fsl = ws ? (t >= f / 2) : (t == 0);
            k   = t - skew;
            d   = '0;
            if (k >= 0 && k < nslots * w) begin
                for (int p = 0; p < 4; p++) begin
                    logic [31:0] v;
                    v    = pv(fr, p, k / w);
                    d[p] = lsb ? v[32 - w + (k % w)] : v[31 - (k % w)];
                end
            end
            tick(fsl ^ inv, d);
        end
        fr++;
    endtask

    task automatic drain(input string tag);
        repeat (24) @(negedge clk);
        chk({tag, " scoreboard empty"}, 32'(q_data.size()), 32'd0);
    endtask

    always @(negedge clk) begin
        if (!rst && smp_valid && smp_ready) begin
            seen++;
            checks++;
            if (q_data.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected sample actual=%h/%0d/%0d expected=none",
                         smp_data, smp_lane, smp_slot);
            end else begin
                logic [31:0] ed;
                int          el, es;
                string       et;
                ed = q_data.pop_front();
                el = q_lane.pop_front();
                es = q_slot.pop_front();
                et = q_tag.pop_front();
                if (smp_data !== ed || int'(smp_lane) != el || int'(smp_slot) != es) begin
                    errors++;
                    $display("FAIL %s actual=%h lane %0d slot %0d expected=%h lane %0d slot %0d",
                             et, smp_data, smp_lane, smp_slot, ed, el, es);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int          fsave;
        for (int l = 0; l < 4; l++) begin b_en[l] = '0; b_mute[l] = '0; end
        b_swap = 32'h7654_3210;
        b_mval = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(6'h00, r); chk("R1 ctrl", r, 32'h0);
        rd(6'h04, r); chk("R1 swap", r, 32'h7654_3210);
        rd(6'h08, r); chk("R1 slot enable lane0", r, 32'h0);
        rd(6'h2C, r); chk("R1 slot mute lane3", r, 32'h0);
        chk("R1 valid", {31'd0, smp_valid}, 32'd0);

        // R2 field positions and register readback
        wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, r); chk("R2 ctrl fields", r, 32'hF2F7_003F);
        wr(6'h00, 32'h0);
        wr(6'h14, 32'h1234_5678); rd(6'h14, r); chk("R2 slot enable lane3", r, 32'h1234_5678);
        wr(6'h1C, 32'hCAFE_0001); rd(6'h1C, r); chk("R2 mute value", r, 32'hCAFE_0001);
        wr(6'h14, 32'h0);

        // R3 R5 R8 MSB-first, 16-bit slots, skew 1, all lanes
        src = 5; src_bclk = '0;
        for (int l = 0; l < 4; l++) begin b_en[l] = 32'hF; wr(6'(8 + 4 * l), b_en[l]); end
        bring_up((32'd5 << 20) | (32'd1 << 16) | 32'd15);
        tick(1'b0, 4'h0); tick(1'b0, 4'h0);
        send_frame(1, 16, 4, 3, 0, 0, 0, 1, "R3 R5 R8 msb w16");
        send_frame(1, 16, 4, 3, 0, 0, 0, 1, "R3 R5 R8 msb w16");
        drain("R3");

        // R4 R8 LSB-first, 8-bit slots, skew 3, sparse masks
        wr(6'h00, 32'h0);
        b_en[0] = 32'h5; b_en[1] = 32'h2; b_en[2] = 32'h7; b_en[3] = 32'h0;
        for (int l = 0; l < 4; l++) wr(6'(8 + 4 * l), b_en[l]);
        bring_up((32'd5 << 20) | (32'd3 << 16) | LSB | 32'd7);
        tick(1'b0, 4'h0);
        send_frame(3, 8, 3, 3, 0, 0, 1, 1, "R4 R8 lsb w8");
        send_frame(3, 8, 3, 3, 0, 0, 1, 1, "R4 R8 lsb w8");
        drain("R4");

        // R9 R10 mute and lane swap, 12-bit slots, skew 2
        wr(6'h00, 32'h0);
        b_swap = 32'h7654_0123; wr(6'h04, b_swap);
        b_mval = 32'h1357_9BDF; wr(6'h1C, b_mval);
        for (int l = 0; l < 4; l++) begin b_en[l] = 32'h7; wr(6'(8 + 4 * l), b_en[l]); end
        b_mute[1] = 32'h2; b_mute[3] = 32'h1;
        for (int l = 0; l < 4; l++) wr(6'(32 + 4 * l), b_mute[l]);
        bring_up((32'd5 << 20) | (32'd2 << 16) | 32'd11);
        tick(1'b0, 4'h0);
        send_frame(2, 12, 3, 2, 0, 0, 0, 1, "R9 R10 mute swap");
        drain("R9 R10");

        // R6 R7 word-select mode, inverted sync, source 9, 32-bit slots
        wr(6'h00, 32'h0);
        for (int l = 0; l < 4; l++) begin b_mute[l] = 0; wr(6'(32 + 4 * l), 32'h0); end
        b_swap = 32'h7654_3210; wr(6'h04, b_swap);
        b_en[0] = 32'h3; b_en[1] = 32'h1; b_en[2] = 32'h3; b_en[3] = 32'h1;
        for (int l = 0; l < 4; l++) wr(6'(8 + 4 * l), b_en[l]);
        src = 9; src_bclk = '0; src_fsync = '1;
        bring_up(WSM | INV | (32'd9 << 20) | (32'd1 << 16) | 32'd31);
        tick(1'b0, 4'h0); tick(1'b0, 4'h0);
        send_frame(1, 32, 2, 2, 1, 1, 0, 1, "R6 R7 word select");
        send_frame(1, 32, 2, 2, 1, 1, 0, 1, "R6 R7 word select");
        drain("R6 R7");

        // R12 enable clear: nothing captured
        fsave = seen;
        wr(6'h00, ORN | IRN | (32'd9 << 20) | (32'd1 << 16) | 32'd31 | WSM | INV);
        send_frame(1, 32, 2, 2, 1, 1, 0, 0, "R12");
        repeat (24) @(negedge clk);
        chk("R12 disabled output count", 32'(seen - fsave), 32'd0);

        // R11 overflow with consumer stalled
        wr(6'h00, 32'h0);
        b_en[0] = 32'h3; b_en[1] = 0; b_en[2] = 0; b_en[3] = 0;
        for (int l = 0; l < 4; l++) wr(6'(8 + 4 * l), b_en[l]);
        src = 5; src_bclk = '0;
        smp_ready = 1'b0;
        bring_up((32'd5 << 20) | (32'd1 << 16) | 32'd7);
        tick(1'b0, 4'h0);
        fsave = fr;
        send_frame(1, 8, 2, 2, 0, 0, 0, 0, "R11");
        repeat (16) @(negedge clk);
        chk("R11 valid held", {31'd0, smp_valid}, 32'd1);
        chk("R11 newer slot data", smp_data, pv(fsave, 0, 1) & topmask(8));
        chk("R11 newer slot tag", 32'(smp_slot), 32'd1);
        rd(6'h18, r); chk("R11 flag set", r, 32'd1);
        wr(6'h18, 32'd0); rd(6'h18, r); chk("R11 flag kept on write 0", r, 32'd1);
        wr(6'h18, 32'd1); rd(6'h18, r); chk("R11 flag cleared", r, 32'd0);

        // R12 output-side reset drops pending samples
        wr(6'h00, IRN | EN | (32'd5 << 20) | (32'd1 << 16) | 32'd7);
        repeat (3) @(negedge clk);
        chk("R12 output reset clears valid", {31'd0, smp_valid}, 32'd0);
        smp_ready = 1'b1;
        wr(6'h00, ORN | IRN | EN | (32'd5 << 20) | (32'd1 << 16) | 32'd7);
        repeat (8) @(negedge clk);
        chk("R12 nothing after output reset", {31'd0, smp_valid}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule